// File: doc/BRIEF.md
# Synchronous Serial Port Controller

This block is an 8-bit synchronous serial port with a small register interface for a CPU. It has a control register, a status register and one data address. A write to the data address loads the shift register. A read of the same address returns the last character that was received. With the master bit set, the block generates the serial clock from the system clock through a power-of-two divider, drives the data-out line and samples the data-in line. With the master bit clear, it works as a slave. In that mode it follows a serial clock supplied from outside while its select input is low, and returns data on the slave output line.

The transmit side has a single buffer. A write that arrives during a transfer is refused and flagged as a write collision. The receive side has two stages: each finished character is copied into a separate read buffer, so the shifter can start on the next character at once. If that buffer is still unread when the next character completes, the old character is kept and the new one is dropped. In master mode, a low level on the select input means another master is driving the bus. The block then raises a mode fault and releases the pins. Software clears flags with a status read followed by the access that matches the flag. An interrupt request combines the transfer-done flag and the mode-fault flag.

Top module: `spi_link`

## Requirements
- R1: Address 0 is the control register. Bit 7 is the interrupt enable, bit 6 enable, bit 5 LSB-first, bit 4 master, bit 3 clock polarity (the idle level), bit 2 clock phase, and bits 1:0 the rate. Address 1 is status, read-only: bit 7 done, bit 6 write collision, bit 4 mode fault, all other bits 0. A write to address 2 loads the shifter and a read of address 2 returns the read buffer. After reset both registers and the read buffer are zero.
- R2: A master transfer moves 8 bits. It sends the shifter on the master data-out pin and collects 8 bits from the master data-in pin. Bit 7 goes first when LSB-first is 0 and bit 0 goes first when it is 1. The same order applies on receive.
- R3: With phase 0, the first bit is on the line before the first clock edge, the receiver samples on the leading edge (the edge that leaves the idle level) and the sender shifts on the trailing edge. With phase 1, the sender shifts on the leading edge and the receiver samples on the trailing edge.
- R4: In master mode, each serial-clock half period lasts 2^rate system clocks. The done flag reads 1 exactly 16·2^rate + 1 clocks after the clock edge that takes the data write, and not one clock earlier.
- R5: In slave mode with the select input low, the block follows the external serial clock with half periods as short as one system clock. It receives on the slave data-in pin, sends on the slave data-out pin, and sets done after 8 bits.
- R6: In slave mode with the select input high, the external clock is ignored. No bits shift, done stays clear, and the slave data-out pin is not driven.
- R7: A data write during a transfer sets the write-collision flag and leaves the shifter unchanged.
- R8: If a character completes while done is still set, the read buffer keeps the older character and the new one is lost. Once done has been cleared, the next character is stored.
- R9: If the select input is low while the block is enabled as master, the mode-fault flag is set on the next clock, the enable and master control bits are cleared, and the transfer is dropped.
- R10: A status read taken while a flag is set arms that flag. A later data-address access then clears done and write collision, and a later control write clears mode fault.
- R11: The interrupt request is high exactly when the interrupt enable is set and done or mode fault is set.
- R12: When enable is clear, no pin is driven. An enabled master drives the clock and master data-out pins. An enabled slave drives only its slave data-out pin, and only while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address (0 control, 1 status, 2 data) |
| busWr | input | 1 | Write strobe, one clock per access |
| busRd | input | 1 | Read strobe, one clock per access; arms and clears flags |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock from outside (slave mode) |
| sckOut | output | 1 | Generated serial clock (master mode) |
| sckOe | output | 1 | Drive enable for the serial clock pin |
| mosiIn | input | 1 | Slave data in |
| mosiOut | output | 1 | Master data out |
| mosiOe | output | 1 | Drive enable for master data out |
| misoIn | input | 1 | Master data in |
| misoOut | output | 1 | Slave data out |
| misoOe | output | 1 | Drive enable for slave data out |
| ssIn | input | 1 | Select input (slave select, or fault sense in master mode) |

## Verification
A wrong edge index or a wrong shift rule shows up at once on the data-out pin: a bit goes out early, late or reversed, and a bench peer that captures on the correct edge sees a different byte. A miscounted divider moves the done flag by at least one clock from its fixed arrival time. Flag and arming errors show up on the next status read or on irq in the following cycle. A read buffer that is overwritten during overrun, or that never updates, shows on the first data read after the flags are cleared.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;

  localparam int WORD_W = 8;
  localparam int RATE_W = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // control register layout, most significant field first
  typedef struct packed {
    logic              irqEn;
    logic              enable;
    logic              lsbFirst;
    logic              master;
    logic              cpol;
    logic              cpha;
    logic [RATE_W-1:0] rate;
  } cfg_t;

  typedef struct packed {
    logic done;
    logic wcol;
    logic modf;
  } flags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;
    logic mEdge;
    logic abort;
  } strobe_t;

endpackage

// File: rtl/spi_link_ctrl.sv
module spi_link_ctrl
  import spi_link_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              ssIn,
  input  logic              running,
  input  logic              xferDone,
  input  logic [DATA_W-1:0] rxWord,
  output cfg_t              cfg,
  output flags_t            flags,
  output logic [DATA_W-1:0] rxBuf,
  output strobe_t           stb,
  output logic              irq
);

  localparam int DIV_W = 1 << RATE_W;

  logic             ctrlWr, statRd, dataWr, dataAcc;
  logic             modeFault, clrDone, clrWcol, clrModf, doneHeld;
  flags_t           armed;
  logic [DIV_W-1:0] divCnt, divLimit;
  logic             divRun;

  assign ctrlWr  = busWr && (busAddr == ADDR_CTRL);
  assign statRd  = busRd && (busAddr == ADDR_STAT);
  assign dataWr  = busWr && (busAddr == ADDR_DATA);
  assign dataAcc = (busWr || busRd) && (busAddr == ADDR_DATA);

  assign modeFault = cfg.enable && cfg.master && !ssIn;

  assign clrDone  = dataAcc && armed.done;
  assign clrWcol  = dataAcc && armed.wcol;
  assign clrModf  = ctrlWr && armed.modf;
  assign doneHeld = flags.done && !clrDone;

  assign divLimit = (DIV_W'(1) << cfg.rate) - DIV_W'(1);
  assign divRun   = running && cfg.master && cfg.enable;

  always_comb begin
    stb.loadTx = dataWr && !running;
    stb.mEdge  = divRun && (divCnt == divLimit);
    stb.abort  = !cfg.enable || modeFault;
  end

  assign irq = cfg.irqEn && (flags.done || flags.modf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      flags  <= '0;
      armed  <= '0;
      rxBuf  <= '0;
      divCnt <= '0;
    end else begin
      if (ctrlWr) cfg <= cfg_t'(busWdata);
      if (modeFault) begin
        cfg.enable <= 1'b0;
        cfg.master <= 1'b0;
      end

      if (statRd) begin
        armed <= flags;
      end else begin
        if (dataAcc) begin
          armed.done <= 1'b0;
          armed.wcol <= 1'b0;
        end
        if (ctrlWr) armed.modf <= 1'b0;
      end

      flags.done <= doneHeld || xferDone;
      flags.wcol <= (flags.wcol && !clrWcol) || (dataWr && running);
      flags.modf <= (flags.modf && !clrModf) || modeFault;

      if (xferDone && !doneHeld) rxBuf <= rxWord;

      if (!divRun || stb.mEdge) divCnt <= '0;
      else                      divCnt <= divCnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/spi_link_datapath.sv
module spi_link_datapath
  import spi_link_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              master,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsbFirst,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] txWord,
  input  logic              sckIn,
  input  logic              ssIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              running,
  output logic              xferDone,
  output logic [DATA_W-1:0] rxWord,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOut,
  output logic              mosiOe,
  output logic              misoOut,
  output logic              misoOe
);

  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);

  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  edgeIdx;
  logic              sampleBit, sckQ;
  logic              slaveSel, edgeNow, inBit, outBit;
  logic              isSample, lastEdge, cancel;

  function automatic logic [DATA_W-1:0] shiftIn(input logic [DATA_W-1:0] v,
                                                input logic b, input logic lsb);
    return lsb ? {b, v[DATA_W-1:1]} : {v[DATA_W-2:0], b};
  endfunction

  assign slaveSel = enable && !master && !ssIn;
  assign edgeNow  = master ? stb.mEdge : (slaveSel && (sckIn != sckQ));
  assign inBit    = master ? misoIn : mosiIn;
  assign outBit   = lsbFirst ? sh[0] : sh[DATA_W-1];
  assign isSample = (edgeIdx[0] == cpha);
  assign lastEdge = (edgeIdx == LAST_EDGE);
  assign cancel   = stb.abort || (!master && ssIn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      edgeIdx   <= '0;
      sampleBit <= 1'b0;
      sckQ      <= 1'b0;
      running   <= 1'b0;
      xferDone  <= 1'b0;
      rxWord    <= '0;
    end else begin
      sckQ     <= sckIn;
      xferDone <= 1'b0;
      if (stb.loadTx) begin
        sh      <= txWord;
        edgeIdx <= '0;
        running <= master && !stb.abort;
      end else if (cancel) begin
        edgeIdx <= '0;
        running <= 1'b0;
      end else if (edgeNow) begin
        if (isSample) sampleBit <= inBit;
        else if (!(cpha && edgeIdx == '0)) sh <= shiftIn(sh, sampleBit, lsbFirst);
        if (lastEdge) begin
          rxWord   <= shiftIn(sh, cpha ? inBit : sampleBit, lsbFirst);
          xferDone <= 1'b1;
          edgeIdx  <= '0;
          running  <= 1'b0;
        end else begin
          edgeIdx <= edgeIdx + CNT_W'(1);
          running <= 1'b1;
        end
      end
    end
  end

  assign sckOut  = cpol ^ (running && edgeIdx[0]);
  assign sckOe   = enable && master;
  assign mosiOut = outBit;
  assign mosiOe  = enable && master;
  assign misoOut = outBit;
  assign misoOe  = slaveSel;

endmodule

// File: rtl/spi_link.sv
module spi_link
  import spi_link_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic              irq,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssIn
);

  cfg_t              cfg;
  flags_t            flags;
  strobe_t           stb;
  logic              running, xferDone;
  logic [WORD_W-1:0] rxWord, rxBuf;

  spi_link_ctrl #(.DATA_W(WORD_W)) uCtl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .ssIn(ssIn), .running(running), .xferDone(xferDone),
    .rxWord(rxWord), .cfg(cfg), .flags(flags), .rxBuf(rxBuf), .stb(stb), .irq(irq)
  );

  spi_link_datapath #(.DATA_W(WORD_W)) uDp (
    .clk(clk), .rst_n(rst_n), .enable(cfg.enable), .master(cfg.master),
    .cpol(cfg.cpol), .cpha(cfg.cpha), .lsbFirst(cfg.lsbFirst), .stb(stb),
    .txWord(busWdata), .sckIn(sckIn), .ssIn(ssIn), .mosiIn(mosiIn), .misoIn(misoIn),
    .running(running), .xferDone(xferDone), .rxWord(rxWord),
    .sckOut(sckOut), .sckOe(sckOe), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoOut(misoOut), .misoOe(misoOe)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = cfg;
      ADDR_STAT: busRdata = {flags.done, flags.wcol, 1'b0, flags.modf, 4'b0000};
      ADDR_DATA: busRdata = rxBuf;
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_link_checker.sv
module spi_link_checker
  import spi_link_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic              ssIn,
  input logic              cfgEn,
  input logic              cfgMaster,
  input logic              cfgIrqEn,
  input flags_t            flags,
  input logic              running,
  input logic              xferDone,
  input logic              mEdge,
  input logic [WORD_W-1:0] rxBuf,
  input logic              sckOut,
  input logic              sckOe,
  input logic              mosiOe,
  input logic              misoOe,
  input logic              irq
);

  logic dataAcc;
  assign dataAcc = (busWr || busRd) && (busAddr == ADDR_DATA);

  // R9: a low select while enabled as master faults and releases the bus
  a_r9_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgEn && cfgMaster && !ssIn) |=> (flags.modf && !cfgEn && !cfgMaster));

  // R7: a data write during a transfer raises the collision flag
  a_r7_collision_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == ADDR_DATA && running) |=> flags.wcol);

  // R8: a completion while done is still pending leaves the read buffer alone
  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (xferDone && flags.done && !dataAcc) |=> $stable(rxBuf));

  // R2: every completed character raises done
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    xferDone |=> flags.done);

  // R4: the generated clock only moves on a divider edge
  a_r4_sck_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cfgEn && cfgMaster && ssIn && !mEdge && !(busWr && busAddr == ADDR_CTRL))
      |=> $stable(sckOut));

  // R12: nothing is driven while the block is disabled
  a_r12_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgEn |-> !(sckOe || mosiOe || misoOe));

  // R6: a deselected slave never drives its output
  a_r6_deselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgMaster && ssIn) |-> !misoOe);

  // R11: the request needs its enable and a pending flag
  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfgIrqEn && (flags.done || flags.modf)));

endmodule

bind spi_link spi_link_checker uChk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .ssIn(ssIn), .cfgEn(cfg.enable), .cfgMaster(cfg.master), .cfgIrqEn(cfg.irqEn),
  .flags(flags), .running(running), .xferDone(xferDone), .mEdge(stb.mEdge),
  .rxBuf(rxBuf), .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe), .misoOe(misoOe),
  .irq(irq)
);

// File: tb/spi_link_test.sv
module spi_link_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] busAddr;
  logic       busWr, busRd;
  logic [7:0] busWdata, busRdata;
  logic       irq, sckIn, sckOut, sckOe, mosiIn, mosiOut, mosiOe;
  logic       misoIn, misoOut, misoOe, ssIn;

  int  total = 0, fails = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  spi_link uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .sckIn(sckIn),
    .sckOut(sckOut), .sckOe(sckOe), .mosiIn(mosiIn), .mosiOut(mosiOut),
    .mosiOe(mosiOe), .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .ssIn(ssIn)
  );

  // ---- bench slave peer for master transfers ----
  logic [7:0] slvTx, mosiCap;
  logic       mCpol, mCpha, mLsb;
  int         leadCnt = 0, trailCnt = 0, leadBase = 0, trailBase = 0;

  function automatic int posOf(input int k, input logic lsb);
    return lsb ? k : 7 - k;
  endfunction
  function automatic int clamp7(input int k);
    return (k < 0) ? 0 : ((k > 7) ? 7 : k);
  endfunction

  assign misoIn = slvTx[posOf(mCpha ? clamp7(leadCnt - leadBase - 1)
                                    : clamp7(trailCnt - trailBase), mLsb)];

  always @(sckOut) begin
    if (sckOut != mCpol) begin
      if (!mCpha && (leadCnt - leadBase) < 8)
        mosiCap[posOf(leadCnt - leadBase, mLsb)] = mosiOut;
      leadCnt = leadCnt + 1;
    end else begin
      if (mCpha && (trailCnt - trailBase) < 8)
        mosiCap[posOf(trailCnt - trailBase, mLsb)] = mosiOut;
      trailCnt = trailCnt + 1;
    end
  end

  // ---- helpers ----
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #0.5 d = busRdata;
  endtask

  function automatic logic [7:0] mkCtrl(input logic ie, en, lsb, mst, cp, ph,
                                        input logic [1:0] rate);
    return {ie, en, lsb, mst, cp, ph, rate};
  endfunction

  task automatic clearFlags();
    logic [7:0] d;
    busRead(2'd1, d);
    busRead(2'd2, d);
  endtask

  task automatic armPeer(input logic cp, ph, lsb, input logic [7:0] slv);
    mCpol = cp; mCpha = ph; mLsb = lsb; slvTx = slv;
    leadBase = leadCnt; trailBase = trailCnt; mosiCap = 8'h00;
  endtask

  task automatic waitDone(input string req);
    logic [7:0] s;
    int n;
    n = 0;
    s = 8'h00;
    while (n < 400 && !s[7]) begin
      @(negedge clk);
      peek(2'd1, s);
      n++;
    end
    check(s[7], req, {24'h0, s}, 32'h80);
  endtask

  // irqEn, cpol, cpha, lsb, rate[1:0], tx[7:0], slv[7:0]
  localparam logic [21:0] VEC [6] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 8'h96, 8'hC3},
    {1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h01, 8'h80},
    {1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 8'h7E, 8'h5A},
    {1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 8'h0F, 8'hF1},
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 8'hE4, 8'h27}
  };

  task automatic slaveRun(input logic cp, ph, lsb, input logic [7:0] tx, mst,
                          input bit ignoreTest);
    logic [7:0] d, cap;
    cap = 8'h00;
    sckIn = cp;
    busWrite(2'd0, mkCtrl(1'b0, 1'b1, lsb, 1'b0, cp, ph, 2'd0));
    busWrite(2'd2, tx);
    if (ignoreTest) begin
      check(!misoOe, "R6 slave out released while deselected", misoOe, 0);
      for (int i = 0; i < 16; i++) begin
        @(negedge clk); sckIn = ~sckIn;
      end
      @(negedge clk); @(negedge clk);
      peek(2'd1, d);
      check(d[7] == 1'b0, "R6 done stays clear with select high", d, 0);
    end
    @(negedge clk);
    ssIn = 1'b0;
    #0.5 check(misoOe, "R12 selected slave drives its output", misoOe, 1);
    for (int k = 0; k < 8; k++) begin
      int b;
      b = posOf(k, lsb);
      if (!ph) begin
        @(negedge clk);
        mosiIn = mst[b]; cap[b] = misoOut; sckIn = ~cp;
        @(negedge clk);
        sckIn = cp;
      end else begin
        @(negedge clk);
        sckIn = ~cp;
        @(negedge clk);
        mosiIn = mst[b]; cap[b] = misoOut; sckIn = cp;
      end
    end
    @(negedge clk); @(negedge clk);
    ssIn = 1'b1;
    peek(2'd1, d);
    check(d[7], "R5 slave sets done after 8 bits", d, 8'h80);
    check(cap == tx, "R5 slave sends loaded word", cap, tx);
    busRead(2'd1, d);
    busRead(2'd2, d);
    check(d == mst, "R5 slave receives word", d, mst);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; busAddr = 2'd0; busWr = 1'b0; busRd = 1'b0; busWdata = 8'h00;
    sckIn = 1'b0; mosiIn = 1'b0; ssIn = 1'b1;
    mCpol = 1'b0; mCpha = 1'b0; mLsb = 1'b0; slvTx = 8'h00; mosiCap = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    peek(2'd0, d); check(d == 8'h00, "R1 control resets to zero", d, 0);
    peek(2'd1, d); check(d == 8'h00, "R1 status resets to zero", d, 0);
    peek(2'd2, d); check(d == 8'h00, "R1 read buffer resets to zero", d, 0);
    check(!(sckOe || mosiOe || misoOe), "R12 no pin driven after reset",
          {sckOe, mosiOe, misoOe}, 0);
    check(!irq, "R11 no request after reset", irq, 0);
    rst_n = 1'b1;

    // table-driven master transfers
    for (int i = 0; i < 6; i++) begin
      logic       ie, cp, ph, lsb;
      logic [1:0] rt;
      logic [7:0] tx, slv;
      {ie, cp, ph, lsb, rt, tx, slv} = VEC[i];
      busWrite(2'd0, mkCtrl(ie, 1'b1, lsb, 1'b1, cp, ph, rt));
      check(sckOe && mosiOe && !misoOe, "R12 master drives clock and data out",
            {sckOe, mosiOe, misoOe}, 3'b110);
      armPeer(cp, ph, lsb, slv);
      busWrite(2'd2, tx);
      waitDone("R2 master done");
      check(mosiCap == tx, "R3 peer captures sent word on its sample edge", mosiCap, tx);
      check(irq == ie, "R11 request follows enable and done", irq, ie);
      busRead(2'd1, d);
      check(d == 8'h80, "R1 status shows only done", d, 8'h80);
      busRead(2'd2, d);
      check(d == slv, "R2 received word in read buffer", d, slv);
      peek(2'd1, d);
      check(d[7] == 1'b0, "R10 done cleared by status then data read", d, 0);
    end

    // R4: exact completion time at rate 1
    busWrite(2'd0, mkCtrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1));
    armPeer(1'b0, 1'b0, 1'b0, 8'h00);
    busWrite(2'd2, 8'h55);
    repeat (32) @(posedge clk);
    @(negedge clk);
    peek(2'd1, d); check(d[7] == 1'b0, "R4 done not yet one clock early", d, 0);
    @(negedge clk);
    peek(2'd1, d); check(d[7] == 1'b1, "R4 done at 16*2^rate+1 clocks", d, 8'h80);
    clearFlags();

    // R7: write collision
    busWrite(2'd0, mkCtrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2));
    armPeer(1'b0, 1'b0, 1'b0, 8'h11);
    busWrite(2'd2, 8'h3A);
    repeat (10) @(negedge clk);
    busWrite(2'd2, 8'hFF);
    peek(2'd1, d); check(d[6], "R7 collision flag set", d, 8'h40);
    waitDone("R7 transfer still completes");
    check(mosiCap == 8'h3A, "R7 shifter kept first word", mosiCap, 8'h3A);
    clearFlags();
    peek(2'd1, d); check(d == 8'h00, "R10 done and collision cleared", d, 0);

    // R8: overrun keeps the older character
    busWrite(2'd0, mkCtrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0));
    armPeer(1'b0, 1'b0, 1'b0, 8'h6D);
    busWrite(2'd2, 8'h00);
    waitDone("R8 first transfer");
    armPeer(1'b0, 1'b0, 1'b0, 8'h92);
    busWrite(2'd2, 8'h00);
    repeat (40) @(negedge clk);
    busRead(2'd1, d);
    busRead(2'd2, d);
    check(d == 8'h6D, "R8 unread character kept on overrun", d, 8'h6D);
    armPeer(1'b0, 1'b0, 1'b0, 8'h44);
    busWrite(2'd2, 8'h00);
    waitDone("R8 third transfer");
    busRead(2'd1, d);
    busRead(2'd2, d);
    check(d == 8'h44, "R8 new character stored after clear", d, 8'h44);

    // R9: mode fault
    busWrite(2'd0, mkCtrl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0));
    @(negedge clk);
    ssIn = 1'b0;
    @(negedge clk);
    peek(2'd1, d); check(d[4], "R9 mode fault flag set", d, 8'h10);
    peek(2'd0, d); check(d[6] == 1'b0 && d[4] == 1'b0, "R9 enable and master cleared",
                         d, 8'h80);
    check(!sckOe && !mosiOe, "R9 bus released", {sckOe, mosiOe}, 0);
    check(irq, "R11 request on mode fault", irq, 1);
    ssIn = 1'b1;
    busRead(2'd1, d);
    busWrite(2'd0, 8'h00);
    peek(2'd1, d); check(d[4] == 1'b0, "R10 fault cleared by status then control write", d, 0);
    check(!irq, "R11 request drops with flags clear", irq, 0);

    // slave transfers
    slaveRun(1'b0, 1'b0, 1'b0, 8'hC9, 8'h35, 1'b1);
    slaveRun(1'b1, 1'b1, 1'b1, 8'h5B, 8'hA2, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule